// File: doc/BRIEF.md
# Multiplexed-Bus Parallel Port Expander

This block gives a small microcontroller three 8-bit general-purpose ports, 24 lines in all. Every line has its own direction bit, so software alone picks which lines drive and which listen; nothing has to be reprogrammed. Each pin is presented as three signals: an output value, an output enable and a sampled input level. The pad ring turns these into a tri-state pad.

The host reaches the block over an 8-bit bus that carries both address and data. While ALE is high, the low three bits of the bus select a register. Once ALE drops, the same bus carries write data or read data, steered by the active-low chip-enable, read and write strobes. The bus is also modelled as separate input, output and enable signals. Every strobe is sampled on the block clock. Reset is asynchronous active-low and is released synchronously inside the block.

Top module: `pexp_top`

## Requirements
- R1: After reset release, every pin_oe and pin_out bit is 0, bus_oe is 0, and the three direction registers read back as 0x00.
- R2: At each clock edge where ale is 1, the register address is taken from bus_in[2:0]. It is held unchanged while ale is 0. The bus bits above bit 2 play no part in the address.
- R3: A write happens when cs_n and wr_n are both low and ale is low. It stores bus_in into the register at the held address. The map is: 0, 1 and 2 select the data registers of ports A, B and C; 4, 5 and 6 select the direction registers of ports A, B and C.
- R4: A write strobe has no effect while cs_n is high or while ale is high.
- R5: Port A uses pin bits 7:0, port B uses 15:8 and port C uses 23:16. For every pin, pin_oe equals that pin's direction bit (1 means output) and pin_out equals that pin's data register bit. Both take the new value one clock after the write.
- R6: Reading a data address returns the pin_in levels of that port. Reading a direction address returns that direction register.
- R7: Addresses 3 and 7 read as 0x00, and writes to them change no register.
- R8: bus_oe is 1 in the cycle after an edge at which cs_n and rd_n are low and ale is low, and 0 otherwise. With bus_oe high, bus_out holds the read data for the held address.
- R9: Each low period of wr_n writes once. Only the data present at its first qualifying clock edge is stored, even if bus_in changes while wr_n stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch enable, high during the address phase |
| cs_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 8 | Multiplexed address/data from the host |
| bus_out | output | 8 | Read data toward the host |
| bus_oe | output | 1 | Drive enable for the host bus |
| pin_in | input | 24 | Sampled levels of the port pins |
| pin_out | output | 24 | Output values of the port pins |
| pin_oe | output | 24 | Per-pin output enable |

## Verification
An address phase and a write strobe can occur in the same clock: the host raises ALE while chip enable and write are both low. The bench provokes exactly this. The bus carries a byte whose low bits name a different register, and ALE and the strobe are dropped together one cycle later. The result is judged without a fresh address phase:
- a read must return the register named by that byte, which shows the address moved;
- no pin output or enable may change, which shows the write was dropped.

// File: rtl/pexp_pkg.sv
package pexp_pkg;

  // Host strobes after conversion to active-high form.
  typedef struct packed {
    logic ale;
    logic cs;
    logic rd;
    logic wr;
  } bus_strobe_t;

endpackage

// File: rtl/pexp_rst_sync.sv
module pexp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/pexp_bus_ctrl.sv
module pexp_bus_ctrl
  import pexp_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_strobe_t       strb,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_pulse,
  output logic              rd_req
);

  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;
  logic              wr_act;
  logic              wr_act_q;

  // next-state
  always_comb begin
    addr_en  = strb.ale;
    addr_d   = addr_in;
    wr_act   = strb.cs & strb.wr & ~strb.ale;
    rd_req   = strb.cs & strb.rd & ~strb.ale;
    wr_pulse = wr_act & ~wr_act_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wr_act_q <= 1'b0;
    end else begin
      if (addr_en) begin
        addr_q <= addr_d;
      end
      wr_act_q <= wr_act;
    end
  end

  a_r2_addr_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !strb.ale |=> $stable(addr_q));

  a_r4_no_write_idle : assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.cs || strb.ale) |-> !wr_pulse);

  a_r9_single_write : assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

endmodule

// File: rtl/pexp_port.sv
module pexp_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_data,
  input  logic         we_dir,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q
);

  logic [W-1:0] data_d;
  logic [W-1:0] dir_d;

  // next-state
  always_comb begin
    data_d = wdata;
    dir_d  = wdata;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (we_data) begin
        data_q <= data_d;
      end
      if (we_dir) begin
        dir_q <= dir_d;
      end
    end
  end

  a_r3_data_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !we_data |=> $stable(data_q));

  a_r3_dir_load : assert property (@(posedge clk) disable iff (!rst_n)
    we_dir |=> (dir_q == $past(wdata)));

endmodule

// File: rtl/pexp_rd_mux.sv
module pexp_rd_mux #(
  parameter int unsigned N_PORTS  = 3,
  parameter int unsigned W        = 8,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DIR_BASE = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [N_PORTS*W-1:0] pins,
  input  logic [N_PORTS*W-1:0] dirs,
  output logic [W-1:0]         rdata
);

  always_comb begin
    rdata = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (addr == ADDR_W'(p)) begin
        rdata = pins[p*W +: W];
      end
      if (addr == ADDR_W'(DIR_BASE + p)) begin
        rdata = dirs[p*W +: W];
      end
    end
  end

endmodule

// File: rtl/pexp_top.sv
module pexp_top
  import pexp_pkg::*;
#(
  parameter int unsigned N_PORTS  = 3,
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DIR_BASE = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ale,
  input  logic                      cs_n,
  input  logic                      rd_n,
  input  logic                      wr_n,
  input  logic [PORT_W-1:0]         bus_in,
  output logic [PORT_W-1:0]         bus_out,
  output logic                      bus_oe,
  input  logic [N_PORTS*PORT_W-1:0] pin_in,
  output logic [N_PORTS*PORT_W-1:0] pin_out,
  output logic [N_PORTS*PORT_W-1:0] pin_oe
);

  localparam int unsigned PINS = N_PORTS * PORT_W;

  logic              rst_sync_n;
  bus_strobe_t       strb;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_pulse;
  logic              rd_req;
  logic [N_PORTS-1:0] hit_data;
  logic [N_PORTS-1:0] hit_dir;
  logic              unmapped;
  logic [PINS-1:0]   dir_all;
  logic [PINS-1:0]   data_all;
  logic [PORT_W-1:0] rdata;
  logic [PORT_W-1:0] bus_out_q;
  logic              bus_oe_q;

  pexp_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    strb.ale = ale;
    strb.cs  = ~cs_n;
    strb.rd  = ~rd_n;
    strb.wr  = ~wr_n;
  end

  pexp_bus_ctrl #(.ADDR_W(ADDR_W)) i_bus_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .strb    (strb),
    .addr_in (bus_in[ADDR_W-1:0]),
    .addr_q  (addr_q),
    .wr_pulse(wr_pulse),
    .rd_req  (rd_req)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign hit_data[p] = (addr_q == ADDR_W'(p));
    assign hit_dir[p]  = (addr_q == ADDR_W'(DIR_BASE + p));

    pexp_port #(.W(PORT_W)) i_port (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .we_data(wr_pulse & hit_data[p]),
      .we_dir (wr_pulse & hit_dir[p]),
      .wdata  (bus_in),
      .data_q (data_all[p*PORT_W +: PORT_W]),
      .dir_q  (dir_all[p*PORT_W +: PORT_W])
    );
  end

  assign unmapped = ~|(hit_data | hit_dir);

  pexp_rd_mux #(
    .N_PORTS (N_PORTS),
    .W       (PORT_W),
    .ADDR_W  (ADDR_W),
    .DIR_BASE(DIR_BASE)
  ) i_rd_mux (
    .addr (addr_q),
    .pins (pin_in),
    .dirs (dir_all),
    .rdata(rdata)
  );

  // registered host read path
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_out_q <= '0;
      bus_oe_q  <= 1'b0;
    end else begin
      bus_out_q <= rdata;
      bus_oe_q  <= rd_req;
    end
  end

  assign bus_out = bus_out_q;
  assign bus_oe  = bus_oe_q;
  assign pin_out = data_all;
  assign pin_oe  = dir_all;

  a_r8_drive_on : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cs_n && !rd_n && !ale) |=> bus_oe);

  a_r8_drive_off : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs_n || rd_n || ale) |=> !bus_oe);

  a_r7_unmapped_inert : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_pulse && unmapped) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/test_pexp_top.sv
module test_pexp_top;

  logic        clk;
  logic        rst_n;
  logic        ale;
  logic        cs_n;
  logic        rd_n;
  logic        wr_n;
  logic [7:0]  bus_in;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic [23:0] pin_in;
  logic [23:0] pin_out;
  logic [23:0] pin_oe;
  logic [23:0] ext;

  logic [7:0]  exp_data [3];
  logic [7:0]  exp_dir  [3];
  int          n_tests;
  int          n_fail;
  logic [7:0]  rd_val;

  pexp_top i_pexp_top (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .bus_in (bus_in),
    .bus_out(bus_out),
    .bus_oe (bus_oe),
    .pin_in (pin_in),
    .pin_out(pin_out),
    .pin_oe (pin_oe)
  );

  // resolved pad model: driven bits follow the block, others follow the board
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [7:0] a);
    @(negedge clk);
    ale = 1'b1;
    bus_in = a;
    @(negedge clk);
    ale = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    addr_phase(a);
    bus_in = d;
    cs_n = 1'b0;
    wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    wr_n = 1'b1;
  endtask

  task automatic read_held(output logic [7:0] d);
    cs_n = 1'b0;
    rd_n = 1'b0;
    @(negedge clk);
    chk("R8 bus_oe during read", 32'(bus_oe), 32'd1);
    d = bus_out;
    cs_n = 1'b1;
    rd_n = 1'b1;
    @(negedge clk);
    chk("R8 bus_oe after read", 32'(bus_oe), 32'd0);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    addr_phase(a);
    read_held(d);
  endtask

  function automatic logic [7:0] model_rd(input int a);
    logic [7:0] v;
    v = 8'h00;
    if (a < 3) v = (exp_dir[a] & exp_data[a]) | (~exp_dir[a] & ext[a*8 +: 8]);
    else if (a >= 4 && a < 7) v = exp_dir[a-4];
    return v;
  endfunction

  task automatic chk_pins(input string tag);
    chk({tag, " pin_out"}, 32'(pin_out), 32'({exp_data[2], exp_data[1], exp_data[0]}));
    chk({tag, " pin_oe"},  32'(pin_oe),  32'({exp_dir[2],  exp_dir[1],  exp_dir[0]}));
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    rst_n = 1'b0;
    ale = 1'b0;
    cs_n = 1'b1;
    rd_n = 1'b1;
    wr_n = 1'b1;
    bus_in = 8'h00;
    ext = 24'hC3_96_5A;
    for (int p = 0; p < 3; p++) begin
      exp_data[p] = 8'h00;
      exp_dir[p]  = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", 32'(pin_oe), 32'd0);
    chk("R1 pin_out", 32'(pin_out), 32'd0);
    chk("R1 bus_oe", 32'(bus_oe), 32'd0);
    for (int a = 4; a < 7; a++) begin
      do_read(8'(a), rd_val);
      chk("R1 direction readback", 32'(rd_val), 32'd0);
    end

    // R3 R5 R6 sweep over ports and patterns
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 6; k++) begin
        logic [7:0] d;
        logic [7:0] dr;
        d  = 8'(8'h5A ^ (k * 37) ^ (p * 17));
        dr = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 107) ^ (p << 2));
        ext[p*8 +: 8] = 8'(~d ^ (k * 29 + p));
        do_write(8'(p), d);
        exp_data[p] = d;
        do_write(8'(4 + p), dr);
        exp_dir[p] = dr;
        @(negedge clk);
        chk_pins("R5 sweep");
        do_read(8'(4 + p), rd_val);
        chk("R6 direction read", 32'(rd_val), 32'(dr));
        do_read(8'(p), rd_val);
        chk("R6 pin level read", 32'(rd_val), 32'(model_rd(p)));
      end
    end

    // R7 unmapped writes have no effect
    do_write(8'h03, 8'hFF);
    do_write(8'h07, 8'hFF);
    @(negedge clk);
    chk_pins("R7 unmapped write");

    // R2 R6 R7 full address sweep, upper bus bits set during address phase
    ext = 24'h3C_A5_0F;
    for (int a = 0; a < 8; a++) begin
      do_read(8'(8'hA8 | a), rd_val);
      chk("R2 R7 address sweep", 32'(rd_val), 32'(model_rd(a)));
    end

    // R4 write with chip enable inactive
    addr_phase(8'h00);
    bus_in = 8'h99;
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    chk_pins("R4 cs_n high write");

    // R4 R2 write strobe during address phase: address moves, write dropped
    addr_phase(8'h00);
    @(negedge clk);
    ale = 1'b1;
    cs_n = 1'b0;
    wr_n = 1'b0;
    bus_in = 8'h05;
    @(negedge clk);
    ale = 1'b0;
    cs_n = 1'b1;
    wr_n = 1'b1;
    @(negedge clk);
    chk_pins("R4 write under ale");
    read_held(rd_val);
    chk("R2 address taken under write", 32'(rd_val), 32'(exp_dir[1]));

    // R9 long strobe stores only the first byte
    addr_phase(8'h00);
    cs_n = 1'b0;
    wr_n = 1'b0;
    bus_in = 8'h11;
    @(negedge clk);
    bus_in = 8'h22;
    @(negedge clk);
    bus_in = 8'h33;
    @(negedge clk);
    cs_n = 1'b1;
    wr_n = 1'b1;
    exp_data[0] = 8'h11;
    @(negedge clk);
    chk_pins("R9 single write");

    // R8 read strobe with chip enable inactive
    addr_phase(8'h04);
    rd_n = 1'b0;
    @(negedge clk);
    chk("R8 no drive without cs", 32'(bus_oe), 32'd0);
    rd_n = 1'b1;
    @(negedge clk);

    // R3 write then all-output port readback of its data
    do_write(8'h06, 8'hFF);
    exp_dir[2] = 8'hFF;
    do_write(8'h02, 8'h81);
    exp_data[2] = 8'h81;
    @(negedge clk);
    chk_pins("R3 port C output");
    do_read(8'h02, rd_val);
    chk("R3 R6 port C driven level", 32'(rd_val), 32'h81);

    finish_run();
  end

endmodule